// File: doc/BRIEF.md
# External Memory Write Strobe Sequencer

This block is a bus-master controller that carries out single write transfers to asynchronous external memory or memory-mapped peripherals, clocked entirely by the processor clock. A client hands it one write at a time over a valid/ready request channel carrying an address, a data word and a bank index. The controller then walks the external pins through a fixed sequence. First the address and the active-low bank select are driven while the write strobe is still high. Then the write strobe is pulled low, and the data bus is enabled one cycle later. The strobe is released when the access ends. The data bus is held for one cycle after the strobe rises. An optional address-hold cycle and an optional bus-idle cycle can follow. The read strobe stays inactive throughout.

Each bank has its own 9-bit configuration word. It sets an internal wait count and an acknowledge mode. The mode decides whether the access length comes from the counter, from the external acknowledge input, from whichever of the two finishes first, or from both together. The configuration of the addressed bank is captured when a request is accepted, so later changes only affect later transfers.

Back-pressure rules: `req_ready` is high only while the controller is idle. A request transfers on a rising clock edge where `req_valid` and `req_ready` are both high. While the controller is busy, `req_valid` has no effect, and a request that is withdrawn before the next idle cycle is never taken. The `xfer_done` pulse marks the last cycle of a transfer, and `req_ready` rises in the cycle after it.

Top module: `ext_wr_seq`

## Requirements
- R1: `req_ready` is high exactly in idle cycles. A request is captured only on a clock edge with `req_valid` and `req_ready` both high, and a `req_valid` asserted and withdrawn while busy starts no transfer.
- R2: In the cycle after acceptance, address and bank select are driven, `mem_wr_n` is high and `mem_data_oe` is low. `mem_wr_n` falls in the next cycle.
- R3: Mode 00 (counter only): the strobe stays low for W+2 cycles, where W is the wait count, and the acknowledge input is ignored.
- R4: Mode 01 (acknowledge only): acknowledge is sampled in every strobe cycle from the second on. The strobe rises after the first such cycle in which acknowledge is high.
- R5: Mode 10 (either): the strobe rises after the first sampled cycle in which the wait count has expired or acknowledge is high. The count expires in the (W+1)th sampled cycle.
- R6: Mode 11 (both): acknowledge is honoured only once the wait count has expired, so the strobe length is max(W, k)+2 cycles when acknowledge first appears in sampled cycle k (counting from 0).
- R7: `mem_data_oe` is low in the first strobe cycle and high in every later strobe cycle and in the single cycle after the strobe rises. `mem_data` carries the request data while enabled and zero otherwise.
- R8: With the hold bit set, one extra cycle follows the data-hold cycle, with address and select still driven, the strobe high and the data bus disabled.
- R9: With the idle bit set, one extra cycle is appended with all selects released and `req_ready` low, before any new strobe can fall.
- R10: `xfer_done` is a one-cycle pulse in the last cycle of the transfer (1 + hold + idle cycles after the strobe rises), and `req_ready` is high in the following cycle.
- R11: `mem_rd_n` is always high. `mem_sel_n` is active-low one-hot at the requested bank index while the address is driven, and all ones otherwise. Bank b's configuration is `bank_cfg[9b+8 : 9b]` with wait count in bits 4:0, mode in bits 6:5, hold enable in bit 7 and idle enable in bit 8.
- R12: The bank configuration is captured when the request is accepted. A change during a transfer does not alter that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_addr | input | ADDR_W | Write address |
| req_data | input | DATA_W | Write data |
| req_bank | input | BANK_W | Bank select index |
| bank_cfg | input | NBANKS*9 | Per-bank configuration words |
| ack_in | input | 1 | External acknowledge |
| mem_addr | output | ADDR_W | External address bus |
| mem_sel_n | output | NBANKS | Active-low bank selects |
| mem_wr_n | output | 1 | Active-low write strobe |
| mem_rd_n | output | 1 | Active-low read strobe, held high |
| mem_data | output | DATA_W | Write data bus value |
| mem_data_oe | output | 1 | Data bus output enable |
| xfer_done | output | 1 | Final-cycle pulse of a transfer |

## Verification
On every cycle, the embedded assertions check the pin ordering rules: selects one-hot and valid before the strobe falls, data enable confined to the strobe and the cycle after it, read strobe high, and no ready while busy. They also check that each acknowledge mode keeps the access open or closes it in reaction to the counter and acknowledge, and that the done pulse is one cycle long. Only the bench's scenarios can show the exact strobe lengths for chosen wait counts and acknowledge arrival times. The same holds for the presence and placement of the optional hold and idle cycles, the configuration snapshot at acceptance, and a request withdrawn while busy leaving no trace.

// File: rtl/ext_wr_pkg.sv
package ext_wr_pkg;

  localparam int CFG_WAIT_W = 5;

  typedef enum logic [1:0] {
    WM_INT    = 2'b00,
    WM_EXT    = 2'b01,
    WM_EITHER = 2'b10,
    WM_BOTH   = 2'b11
  } wmode_e;

  // Packed MSB first: idle enable, hold enable, mode, wait count
  typedef struct packed {
    logic                  idle_en;
    logic                  hold_en;
    wmode_e                mode;
    logic [CFG_WAIT_W-1:0] wait_n;
  } bank_cfg_t;

  localparam int CFG_W = $bits(bank_cfg_t);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_LEAD,
    ST_ACCESS,
    ST_TAIL,
    ST_HOLD,
    ST_GAP
  } wr_state_e;

endpackage

// File: rtl/ext_wr_cfg_sel.sv
module ext_wr_cfg_sel
  import ext_wr_pkg::*;
#(
  parameter int NBANKS = 4,
  parameter int BANK_W = 2
) (
  input  logic [NBANKS*CFG_W-1:0] cfg_flat,
  input  logic [BANK_W-1:0]       bank_idx,
  output bank_cfg_t               sel_cfg
);

  bank_cfg_t cfg_arr [NBANKS];

  for (genvar b = 0; b < NBANKS; b++) begin : g_unpack
    assign cfg_arr[b] = bank_cfg_t'(cfg_flat[b*CFG_W +: CFG_W]);
  end

  always_comb begin
    sel_cfg = '0;
    for (int b = 0; b < NBANKS; b++) begin
      if (bank_idx == BANK_W'(b)) sel_cfg = cfg_arr[b];
    end
  end

endmodule

// File: rtl/ext_wr_wait_ctr.sv
module ext_wr_wait_ctr
  import ext_wr_pkg::*;
#(
  parameter int WAIT_W = CFG_WAIT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WAIT_W-1:0] wait_val,
  input  wmode_e            mode,
  input  logic              active,
  input  logic              ack,
  output logic              access_end
);

  logic [WAIT_W-1:0] cnt_q;
  logic              cnt_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= wait_val;
    end else if (active && (cnt_q != '0)) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign cnt_zero = (cnt_q == '0);

  always_comb begin
    access_end = 1'b0;
    if (active) begin
      unique case (mode)
        WM_INT:    access_end = cnt_zero;
        WM_EXT:    access_end = ack;
        WM_EITHER: access_end = cnt_zero | ack;
        WM_BOTH:   access_end = cnt_zero & ack;
        default:   access_end = 1'b1;
      endcase
    end
  end

  // R3: counter-only mode keeps the access open while waits remain, whatever ack does
  assert_int_waits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (active && mode == WM_INT && !cnt_zero) |=> active);

  // R4: acknowledge-only mode never closes without acknowledge
  assert_ext_needs_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (active && mode == WM_EXT && !ack) |=> active);

  // R5: either mode closes on acknowledge at once
  assert_either_ack_closes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (active && mode == WM_EITHER && ack) |=> !active);

  // R6: both mode keeps the access open while waits remain, even with ack high
  assert_both_waits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (active && mode == WM_BOTH && !cnt_zero) |=> active);

endmodule

// File: rtl/ext_wr_fsm.sv
module ext_wr_fsm
  import ext_wr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      req_fire,
  input  logic      hold_en,
  input  logic      idle_en,
  input  logic      access_end,
  output wr_state_e state,
  output logic      ready,
  output logic      done,
  output logic      ctr_load,
  output logic      ctr_active
);

  wr_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (req_fire) state_d = ST_SETUP;
      ST_SETUP:  state_d = ST_LEAD;
      ST_LEAD:   state_d = ST_ACCESS;
      ST_ACCESS: if (access_end) state_d = ST_TAIL;
      ST_TAIL: begin
        if (hold_en)      state_d = ST_HOLD;
        else if (idle_en) state_d = ST_GAP;
        else              state_d = ST_IDLE;
      end
      ST_HOLD:   state_d = idle_en ? ST_GAP : ST_IDLE;
      ST_GAP:    state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state      = state_q;
  assign ready      = (state_q == ST_IDLE);
  assign ctr_load   = (state_q == ST_LEAD);
  assign ctr_active = (state_q == ST_ACCESS);
  assign done       = (state_q == ST_GAP)
                    || (state_q == ST_HOLD && !idle_en)
                    || (state_q == ST_TAIL && !hold_en && !idle_en);

  // R2: an accepted request always spends one setup cycle before the strobe
  assert_setup_follows_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && req_fire) |=> (state_q == ST_SETUP));

  // R10: the done pulse lasts one cycle and is followed by idle
  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && ready));

endmodule

// File: rtl/ext_wr_pins.sv
module ext_wr_pins
  import ext_wr_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32,
  parameter int NBANKS = 4,
  parameter int BANK_W = 2
) (
  input  wr_state_e         state,
  input  logic [ADDR_W-1:0] addr_q,
  input  logic [DATA_W-1:0] data_q,
  input  logic [BANK_W-1:0] bank_q,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [NBANKS-1:0] mem_sel_n,
  output logic              mem_wr_n,
  output logic              mem_rd_n,
  output logic [DATA_W-1:0] mem_data,
  output logic              mem_data_oe
);

  logic addr_phase;
  logic strobe_low;

  always_comb begin
    addr_phase = 1'b0;
    strobe_low = 1'b0;
    mem_data_oe = 1'b0;
    unique case (state)
      ST_SETUP:  addr_phase = 1'b1;
      ST_LEAD: begin
        addr_phase = 1'b1;
        strobe_low = 1'b1;
      end
      ST_ACCESS: begin
        addr_phase  = 1'b1;
        strobe_low  = 1'b1;
        mem_data_oe = 1'b1;
      end
      ST_TAIL: begin
        addr_phase  = 1'b1;
        mem_data_oe = 1'b1;
      end
      ST_HOLD:   addr_phase = 1'b1;
      default: begin
        addr_phase  = 1'b0;
        strobe_low  = 1'b0;
        mem_data_oe = 1'b0;
      end
    endcase
  end

  assign mem_wr_n = ~strobe_low;
  assign mem_rd_n = 1'b1;
  assign mem_addr = addr_phase ? addr_q : '0;
  assign mem_data = mem_data_oe ? data_q : '0;

  for (genvar b = 0; b < NBANKS; b++) begin : g_sel
    assign mem_sel_n[b] = ~(addr_phase && (bank_q == BANK_W'(b)));
  end

endmodule

// File: rtl/ext_wr_seq.sv
module ext_wr_seq
  import ext_wr_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32,
  parameter int NBANKS = 4,
  localparam int BANK_W = (NBANKS > 1) ? $clog2(NBANKS) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [DATA_W-1:0]       req_data,
  input  logic [BANK_W-1:0]       req_bank,
  input  logic [NBANKS*CFG_W-1:0] bank_cfg,
  input  logic                    ack_in,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic [NBANKS-1:0]       mem_sel_n,
  output logic                    mem_wr_n,
  output logic                    mem_rd_n,
  output logic [DATA_W-1:0]       mem_data,
  output logic                    mem_data_oe,
  output logic                    xfer_done
);

  bank_cfg_t         req_cfg;
  bank_cfg_t         cfg_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [BANK_W-1:0] bank_q;
  logic              req_fire;
  logic              access_end;
  logic              ctr_load;
  logic              ctr_active;
  wr_state_e         state;

  assign req_fire = req_valid && req_ready;

  ext_wr_cfg_sel #(.NBANKS(NBANKS), .BANK_W(BANK_W)) u_cfg_sel (
    .cfg_flat (bank_cfg),
    .bank_idx (req_bank),
    .sel_cfg  (req_cfg)
  );

  // Request and configuration snapshot at acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
      bank_q <= '0;
      cfg_q  <= '0;
    end else if (req_fire) begin
      addr_q <= req_addr;
      data_q <= req_data;
      bank_q <= req_bank;
      cfg_q  <= req_cfg;
    end
  end

  ext_wr_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_fire   (req_fire),
    .hold_en    (cfg_q.hold_en),
    .idle_en    (cfg_q.idle_en),
    .access_end (access_end),
    .state      (state),
    .ready      (req_ready),
    .done       (xfer_done),
    .ctr_load   (ctr_load),
    .ctr_active (ctr_active)
  );

  ext_wr_wait_ctr #(.WAIT_W(CFG_WAIT_W)) u_wait (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (ctr_load),
    .wait_val   (cfg_q.wait_n),
    .mode       (cfg_q.mode),
    .active     (ctr_active),
    .ack        (ack_in),
    .access_end (access_end)
  );

  ext_wr_pins #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .NBANKS (NBANKS),
    .BANK_W (BANK_W)
  ) u_pins (
    .state       (state),
    .addr_q      (addr_q),
    .data_q      (data_q),
    .bank_q      (bank_q),
    .mem_addr    (mem_addr),
    .mem_sel_n   (mem_sel_n),
    .mem_wr_n    (mem_wr_n),
    .mem_rd_n    (mem_rd_n),
    .mem_data    (mem_data),
    .mem_data_oe (mem_data_oe)
  );

  // R11: at most one bank selected, read strobe never active
  assert_sel_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~mem_sel_n));
  assert_rd_inactive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_n);

  // R2: selects already valid in the cycle before the strobe falls; data off at the fall
  assert_sel_before_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_wr_n) |-> ($past(mem_sel_n) != '1 && !mem_data_oe));

  // R7: data enable only during the strobe or the cycle right after it
  assert_oe_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_data_oe |-> (!mem_wr_n || !$past(mem_wr_n)));

  // R1: no acceptance possible while the strobe is low
  assert_no_ready_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_wr_n |-> !req_ready);

endmodule

// File: tb/ext_wr_seq_tb_top.sv
module ext_wr_seq_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [23:0] req_addr = '0;
  logic [31:0] req_data = '0;
  logic [1:0]  req_bank = '0;
  logic [35:0] bank_cfg;
  logic        ack_in = 1'b0;
  logic [23:0] mem_addr;
  logic [3:0]  mem_sel_n;
  logic        mem_wr_n;
  logic        mem_rd_n;
  logic [31:0] mem_data;
  logic        mem_data_oe;
  logic        xfer_done;

  logic [8:0]  cfg_b [4];
  assign bank_cfg = {cfg_b[3], cfg_b[2], cfg_b[1], cfg_b[0]};

  always #2 clk = ~clk;

  ext_wr_seq dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_data(req_data), .req_bank(req_bank),
    .bank_cfg(bank_cfg), .ack_in(ack_in), .mem_addr(mem_addr),
    .mem_sel_n(mem_sel_n), .mem_wr_n(mem_wr_n), .mem_rd_n(mem_rd_n),
    .mem_data(mem_data), .mem_data_oe(mem_data_oe), .xfer_done(xfer_done)
  );

  typedef struct {
    logic [23:0] addr;
    logic [31:0] data;
    int          bank;
    int          len;
    bit          hold;
    bit          idle;
    int          ack_at;
    bit          ack_force;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Strobe length from the mode rules (cfg: [4:0] wait, [6:5] mode, [7] hold, [8] idle)
  function automatic int strobe_len(input logic [8:0] c, input int a);
    int w;
    w = int'(c[4:0]);
    case (c[6:5])
      2'b00:   return w + 2;
      2'b01:   return a + 1;
      2'b10:   return ((w < a - 1) ? w : a - 1) + 2;
      default: return ((w > a - 1) ? w : a - 1) + 2;
    endcase
  endfunction

  task automatic xfer(input logic [23:0] ad, input logic [31:0] d, input int bk,
                      input int a, input bit f);
    exp_t e;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    e.addr = ad; e.data = d; e.bank = bk; e.ack_at = a; e.ack_force = f;
    e.len  = strobe_len(cfg_b[bk], a);
    e.hold = cfg_b[bk][7];
    e.idle = cfg_b[bk][8];
    q.push_back(e);
    req_addr  = ad;
    req_data  = d;
    req_bank  = 2'(bk);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // Monitor, acknowledge driver and scoreboard
  int  sc = 0;
  int  slen = 0;
  int  oecnt = 0;
  int  after = 0;
  bit  in_xfer = 1'b0;
  bit  want_ready = 1'b0;
  logic       prev_wr_n = 1'b1;
  logic       prev_oe = 1'b0;
  logic [3:0] prev_sel_n = 4'hF;

  always @(negedge clk) begin
    exp_t e;
    logic [3:0] esel;
    if (rst_n) begin
      if (q.size() > 0) e = q[0];
      else begin
        e.addr = '0; e.data = '0; e.bank = 0; e.len = 0; e.hold = 0;
        e.idle = 0; e.ack_at = 1000; e.ack_force = 0;
      end
      esel = ~(4'(1) << e.bank);

      // acknowledge: level from strobe cycle ack_at on, or forced high
      if (!mem_wr_n) begin
        ack_in = e.ack_force || (sc >= e.ack_at);
        sc++;
      end else begin
        sc = 0;
        ack_in = e.ack_force;
      end

      if (want_ready) begin
        chk(req_ready == 1'b1, "R10 ready after done", longint'(req_ready), 1);
        want_ready = 1'b0;
      end

      if (!mem_wr_n && prev_wr_n) begin
        chk(prev_sel_n == esel && prev_wr_n && !prev_oe, "R2 setup cycle",
            longint'(prev_sel_n), longint'(esel));
        chk(mem_addr == e.addr, "R11 address", longint'(mem_addr), longint'(e.addr));
        chk(mem_sel_n == esel, "R11 bank select", longint'(mem_sel_n), longint'(esel));
        chk(!mem_data_oe, "R7 oe low in first strobe cycle", longint'(mem_data_oe), 0);
        chk(!req_ready, "R1 not ready while busy", longint'(req_ready), 0);
        chk(mem_rd_n, "R11 read strobe high", longint'(mem_rd_n), 1);
        slen = 0; oecnt = 0; in_xfer = 1'b1;
      end
      if (!mem_wr_n) begin
        slen++;
        if (mem_data_oe) begin
          oecnt++;
          if (mem_data != e.data)
            chk(1'b0, "R7 data during strobe", longint'(mem_data), longint'(e.data));
        end
      end
      if (mem_wr_n && !prev_wr_n) begin
        chk(slen == e.len, "R3/R4/R5/R6 strobe length", slen, e.len);
        after = 0;
      end
      if (mem_wr_n && in_xfer) begin
        after++;
        if (mem_data_oe) oecnt++;
        if (after == 1)
          chk(mem_data_oe && mem_data == e.data && mem_sel_n == esel,
              "R7 data hold cycle", longint'(mem_data), longint'(e.data));
        if (after == 2 && e.hold)
          chk(mem_sel_n == esel && !mem_data_oe && mem_addr == e.addr,
              "R8 address hold cycle", longint'(mem_sel_n), longint'(esel));
        if (after == 2 + int'(e.hold) && e.idle)
          chk(mem_sel_n == 4'hF && !req_ready, "R9 bus idle cycle",
              longint'(mem_sel_n), 15);
        if (xfer_done) begin
          chk(after == 1 + int'(e.hold) + int'(e.idle), "R10 done position",
              after, 1 + int'(e.hold) + int'(e.idle));
          chk(oecnt == e.len, "R7 data enable cycles", oecnt, e.len);
          void'(q.pop_front());
          in_xfer = 1'b0;
          want_ready = 1'b1;
        end
      end
    end
    prev_wr_n  = mem_wr_n;
    prev_oe    = mem_data_oe;
    prev_sel_n = mem_sel_n;
  end

  initial begin
    for (int b = 0; b < 4; b++) cfg_b[b] = '0;
    repeat (3) @(negedge clk);
    chk(req_ready && mem_wr_n && !mem_data_oe && mem_sel_n == 4'hF && !xfer_done,
        "R1 reset state", longint'(mem_sel_n), 15);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && mem_rd_n && mem_wr_n, "R1 ready after reset", longint'(req_ready), 1);

    // R3 counter only, ack forced high and ignored
    cfg_b[0] = {1'b0, 1'b0, 2'b00, 5'd3};
    xfer(24'h00_1234, 32'hDEAD_BEEF, 0, 1, 1'b1);
    cfg_b[0] = {1'b0, 1'b0, 2'b00, 5'd0};
    xfer(24'h00_0010, 32'h1111_2222, 0, 1, 1'b1);
    // R4 acknowledge only
    cfg_b[1] = {1'b0, 1'b0, 2'b01, 5'd9};
    xfer(24'h12_0000, 32'hA5A5_0001, 1, 4, 1'b0);
    xfer(24'h12_0004, 32'hA5A5_0002, 1, 1, 1'b0);
    // R5 either: ack first, then counter first
    cfg_b[2] = {1'b0, 1'b0, 2'b10, 5'd6};
    xfer(24'h34_0000, 32'h0BAD_F00D, 2, 3, 1'b0);
    cfg_b[2] = {1'b0, 1'b0, 2'b10, 5'd2};
    xfer(24'h34_0008, 32'h7777_8888, 2, 9, 1'b0);
    // R6 both: early ack waits for count, late ack extends, zero count
    cfg_b[3] = {1'b0, 1'b0, 2'b11, 5'd2};
    xfer(24'h56_0000, 32'hC0DE_0001, 3, 1, 1'b0);
    cfg_b[3] = {1'b0, 1'b0, 2'b11, 5'd1};
    xfer(24'h56_0010, 32'hC0DE_0002, 3, 5, 1'b0);
    cfg_b[3] = {1'b0, 1'b0, 2'b11, 5'd0};
    xfer(24'h56_0020, 32'hC0DE_0003, 3, 1, 1'b0);
    // R8 / R9 hold and idle combinations
    cfg_b[2] = {1'b0, 1'b1, 2'b00, 5'd1};
    xfer(24'h70_0000, 32'h0000_00A1, 2, 1, 1'b0);
    cfg_b[2] = {1'b1, 1'b0, 2'b00, 5'd1};
    xfer(24'h70_0004, 32'h0000_00A2, 2, 1, 1'b0);
    cfg_b[2] = {1'b1, 1'b1, 2'b01, 5'd0};
    xfer(24'h70_0008, 32'h0000_00A3, 2, 2, 1'b0);
    // R12 configuration change during a transfer has no effect on it
    cfg_b[1] = {1'b0, 1'b0, 2'b00, 5'd2};
    xfer(24'h0F_0000, 32'hFACE_0001, 1, 1, 1'b0);
    cfg_b[1] = {1'b1, 1'b1, 2'b00, 5'd7};
    // R1 request raised and withdrawn while busy must not start a transfer
    cfg_b[0] = {1'b0, 1'b0, 2'b00, 5'd10};
    xfer(24'h0E_0000, 32'h1234_5678, 0, 1, 1'b0);
    req_addr = 24'hBB_BBBB; req_data = 32'hBBBB_BBBB; req_bank = 2'd3;
    req_valid = 1'b1;
    repeat (4) @(negedge clk);
    req_valid = 1'b0;
    // maximum wait count
    cfg_b[0] = {1'b0, 1'b0, 2'b00, 5'd31};
    xfer(24'hFF_FFFC, 32'hFFFF_0000, 0, 1, 1'b0);
    while (q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(mem_wr_n && mem_sel_n == 4'hF && req_ready, "R1 quiet after last transfer",
        longint'(mem_sel_n), 15);
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 20000, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule